// File: doc/BRIEF.md
# Key Auto-Repeat Load Controller

This block decides when the character code held from the keyboard is moved into the serial transmitter. A keystroke arrives as a one-cycle strobe. The strobe arms the controller and requests one load. If the repeat key is not held, the controller issues that one load and then disarms. If the repeat key is held, a period timer runs while the controller is armed, and each expiry requests another load. With the default period of 12,500,000 cycles at 125 MHz, this gives 10 loads per second.

Every load waits for the transmitter-empty flag. A request that arrives while the transmitter is busy stays pending until the flag is high. Several timer expiries during one busy stretch merge into a single pending request. Releasing the repeat key disarms the controller and discards any pending repeat request. The load output is a single-cycle pulse, and the controller stays idle until a keystroke arms it.

Top module: `keyrep_load_ctrl`

## Requirements
- R1: A keystroke strobe sampled on clock edge k while the transmitter-empty flag is high produces `load_o` high in the cycle after edge k+1.
- R2: With the repeat key released, one keystroke produces exactly one load pulse.
- R3: With the repeat key held from the strobe onward and the transmitter always empty, loads appear after edges k+1, k+1+PERIOD_CYC, k+1+2·PERIOD_CYC and so on.
- R4: A load fires only on an edge where the transmitter-empty flag is high. A keystroke made while the flag is low produces no load until the flag rises, and then exactly one load.
- R5: Without a keystroke since the last disarm, no load is produced, whatever the repeat and empty inputs do.
- R6: Releasing the repeat key stops all further loads, including a repeat request that is still waiting for the empty flag.
- R7: Any number of timer expiries during one busy period give exactly one load when the empty flag returns, and repeat loads continue after that.
- R8: `load_o` is high for one clock cycle per load, unless a new strobe coincides with a load.
- R9: While reset is asserted and directly after it, `load_o` is low.
- R10: A new strobe while repeating restarts the period, so the next repeat load comes PERIOD_CYC cycles after the new strobe's own load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_strobe_i | input | 1 | One-cycle pulse per keystroke |
| repeat_held_i | input | 1 | High while the repeat key is held |
| tx_empty_i | input | 1 | High when the transmitter can take a new code |
| load_o | output | 1 | One-cycle pulse that loads the transmitter |

## Verification
The checker assumes that each keystroke strobe lasts one cycle. It also assumes that a strobe does not land on the edge where a load fires; that is the only case in which two load cycles can sit back to back. The empty flag and the repeat level are treated as synchronous inputs that may change on any edge. The bench drives every input on the falling clock edge and keeps strobes single-cycle. It places strobes either while the controller is idle or at a fixed offset from a known load, so they never coincide with one.

// File: rtl/keyrep_pkg.sv
package keyrep_pkg;
   // Outstanding load requests: one owed to a keystroke, one owed to the timer.
   typedef struct packed {
      logic key;
      logic tick;
   } keyrep_pend_t;

   function automatic int unsigned keyrep_cnt_w(input int unsigned period);
      return (period < 2) ? 1 : $clog2(period);
   endfunction
endpackage

// File: rtl/keyrep_arm.sv
module keyrep_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic strb_i,
   input  logic rpt_i,
   input  logic fire_i,
   output logic armed_o,
   output logic key_pend_o
);
   logic armed_q, key_pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         key_pend_q <= 1'b0;
      end else if (strb_i) begin
         armed_q    <= 1'b1;
         key_pend_q <= 1'b1;
      end else begin
         if (fire_i) key_pend_q <= 1'b0;
         if (!rpt_i && !key_pend_q) armed_q <= 1'b0;
      end
   end

   assign armed_o    = armed_q;
   assign key_pend_o = key_pend_q;
endmodule

// File: rtl/keyrep_period_timer.sv
module keyrep_period_timer #(
   parameter int unsigned PERIOD_CYC = 16,
   parameter int unsigned CNT_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   output logic             tick_o,
   output logic [CNT_W-1:0] cnt_o
);
   generate
      if (PERIOD_CYC < 2) begin : g_every_cycle
         assign tick_o = run_i && !restart_i;
         assign cnt_o  = '0;
      end else begin : g_counter
         localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);
         logic [CNT_W-1:0] cnt_q;
         logic             at_end;

         assign at_end = (cnt_q == LAST);
         assign tick_o = run_i && !restart_i && at_end;

         always_ff @(posedge clk) begin
            if (!rst_n || restart_i || !run_i) cnt_q <= '0;
            else if (at_end)                  cnt_q <= '0;
            else                              cnt_q <= cnt_q + 1'b1;
         end
         assign cnt_o = cnt_q;
      end
   endgenerate
endmodule

// File: rtl/keyrep_load_gate.sv
module keyrep_load_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic key_pend_i,
   input  logic tick_i,
   input  logic rpt_i,
   input  logic empty_i,
   output logic fire_o,
   output logic tick_pend_o,
   output logic load_o
);
   logic tick_pend_q, load_q;

   assign fire_o = (key_pend_i || tick_pend_q) && empty_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_pend_q <= 1'b0;
         load_q      <= 1'b0;
      end else begin
         load_q <= fire_o;
         if (fire_o || !rpt_i) tick_pend_q <= 1'b0;
         else if (tick_i)      tick_pend_q <= 1'b1;
      end
   end

   assign tick_pend_o = tick_pend_q;
   assign load_o      = load_q;
endmodule

// File: rtl/keyrep_load_ctrl.sv
module keyrep_load_ctrl #(
   parameter int unsigned PERIOD_CYC = 12_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_strobe_i,
   input  logic repeat_held_i,
   input  logic tx_empty_i,
   output logic load_o
);
   import keyrep_pkg::*;
   localparam int unsigned CNT_W = keyrep_cnt_w(PERIOD_CYC);

   generate
      if (PERIOD_CYC < 1) begin : g_bad_period
         $error("keyrep_load_ctrl: PERIOD_CYC must be at least 1");
      end
   endgenerate

   keyrep_pend_t     pend;
   logic             armed, fire, tick;
   logic [CNT_W-1:0] cnt;

   keyrep_arm u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .strb_i     (key_strobe_i),
      .rpt_i      (repeat_held_i),
      .fire_i     (fire),
      .armed_o    (armed),
      .key_pend_o (pend.key)
   );

   keyrep_period_timer #(.PERIOD_CYC(PERIOD_CYC), .CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (armed && repeat_held_i),
      .restart_i (key_strobe_i),
      .tick_o    (tick),
      .cnt_o     (cnt)
   );

   keyrep_load_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .key_pend_i  (pend.key),
      .tick_i      (tick),
      .rpt_i       (repeat_held_i),
      .empty_i     (tx_empty_i),
      .fire_o      (fire),
      .tick_pend_o (pend.tick),
      .load_o      (load_o)
   );
endmodule

// File: rtl/keyrep_load_ctrl_chk.sv
module keyrep_load_ctrl_chk #(
   parameter int unsigned CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             key_strobe_i,
   input logic             repeat_held_i,
   input logic             tx_empty_i,
   input logic             load_o,
   input logic             armed,
   input logic             tick_pend,
   input logic [CNT_W-1:0] cnt
);
   assert_load_needs_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> $past(tx_empty_i));

   assert_load_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> $past(armed));

   assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_o && !$past(key_strobe_i)) |=> !load_o);

   assert_tick_needs_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick_pend) |-> ($past(repeat_held_i) && $past(armed)));

   assert_timer_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!armed) && !$past(key_strobe_i)) |-> (cnt == '0));
endmodule

bind keyrep_load_ctrl keyrep_load_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .key_strobe_i  (key_strobe_i),
   .repeat_held_i (repeat_held_i),
   .tx_empty_i    (tx_empty_i),
   .load_o        (load_o),
   .armed         (armed),
   .tick_pend     (pend.tick),
   .cnt           (cnt)
);

// File: tb/keyrep_load_ctrl_tb_top.sv
module keyrep_load_ctrl_tb_top;
   localparam int unsigned P = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strb = 1'b0, rpt = 1'b0, empty = 1'b1;
   logic load;

   int cyc = 0;
   int nload = 0;
   int last_load = -1;
   int wide = 0;
   logic prev_load = 1'b0;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   keyrep_load_ctrl #(.PERIOD_CYC(P)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .key_strobe_i  (strb),
      .repeat_held_i (rpt),
      .tx_empty_i    (empty),
      .load_o        (load)
   );

   always @(posedge clk) begin
      cyc = cyc + 1;
      #1;
      if (load) begin
         nload = nload + 1;
         last_load = cyc;
         if (prev_load) wide = wide + 1;
      end
      prev_load = load;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Pulses the strobe for one cycle and returns the index of the edge that samples it.
   task automatic keystroke(output int k);
      @(negedge clk);
      strb = 1'b1;
      k = cyc + 1;
      @(negedge clk);
      strb = 1'b0;
   endtask

   task automatic t_reset;
      wait_cyc(3);
      chk("R9 load low in reset", int'(load), 0);
      rst_n = 1'b1;
      wait_cyc(2);
      chk("R9 load low after reset", int'(load), 0);
   endtask

   task automatic t_idle;
      int n0 = nload;
      for (int i = 0; i < 40; i++) begin
         rpt = i[2];
         empty = i[1];
         @(negedge clk);
      end
      rpt = 1'b0;
      empty = 1'b1;
      wait_cyc(P * 2);
      chk("R5 no load without keystroke", nload - n0, 0);
   endtask

   task automatic t_single;
      int k, n0;
      n0 = nload;
      wide = 0;
      keystroke(k);
      wait_cyc(P * 4);
      chk("R2 one load per keystroke", nload - n0, 1);
      chk("R1 load timing", last_load, k + 1);
      chk("R8 single-cycle pulse", wide, 0);
   endtask

   task automatic t_busy_single;
      int k, n0, e;
      n0 = nload;
      empty = 1'b0;
      keystroke(k);
      wait_cyc(30);
      chk("R4 no load while busy", nload - n0, 0);
      @(negedge clk);
      empty = 1'b1;
      e = cyc + 1;
      wait_cyc(P * 3);
      chk("R4 one load once empty", nload - n0, 1);
      chk("R4 load timing after empty", last_load, e);
   endtask

   task automatic t_repeat;
      int k, n0, n1;
      n0 = nload;
      wide = 0;
      rpt = 1'b1;
      keystroke(k);
      while (cyc < k + 1 + 4 * P) @(negedge clk);
      chk("R3 five repeat loads", nload - n0, 5);
      chk("R3 repeat spacing", last_load, k + 1 + 4 * P);
      chk("R8 repeat pulses single-cycle", wide, 0);
      rpt = 1'b0;
      n1 = nload;
      wait_cyc(P * 3);
      chk("R6 release stops loads", nload - n1, 0);
   endtask

   task automatic t_busy_repeat;
      int k, n0, n1, e;
      rpt = 1'b1;
      keystroke(k);
      while (cyc < k + 1) @(negedge clk);
      n0 = nload;
      empty = 1'b0;
      wait_cyc(P * 3 + 5);
      chk("R7 no load during busy", nload - n0, 0);
      empty = 1'b1;
      e = cyc + 1;
      wait_cyc(3);
      chk("R7 merged ticks give one load", nload - n0, 1);
      chk("R7 merged load timing", last_load, e);
      n1 = nload;
      wait_cyc(P * 2);
      chk("R7 repeats resume", (nload - n1) >= 1, 1);
      // Park a repeat request behind a busy transmitter, then release repeat.
      empty = 1'b0;
      wait_cyc(P + 2);
      rpt = 1'b0;
      wait_cyc(2);
      n1 = nload;
      empty = 1'b1;
      wait_cyc(P * 3);
      chk("R6 pending repeat discarded", nload - n1, 0);
   endtask

   task automatic t_restart;
      int k, k2, n0;
      rpt = 1'b1;
      keystroke(k);
      while (cyc < k + 10) @(negedge clk);
      n0 = nload;
      keystroke(k2);
      while (cyc < k2 + P) @(negedge clk);
      chk("R10 only restart load before new period", nload - n0, 1);
      chk("R10 restart load timing", last_load, k2 + 1);
      wait_cyc(1);
      chk("R10 period measured from new strobe", last_load, k2 + 1 + P);
      rpt = 1'b0;
      wait_cyc(P * 2);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_idle();
            t_single();
            t_busy_single();
            t_repeat();
            t_busy_repeat();
            t_restart();
         end
         begin
            wait_cyc(100000);
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule